// File: doc/BRIEF.md
# Inter-transfer deselect delay timer

This block sits beside the transfer sequencer of a queued SPI master and holds the link idle between two consecutive serial transfers. A peripheral may need its chip select released for a minimum time before the next transfer. A serial A/D converter may need time to finish a conversion. The timer covers both cases. When a transfer finishes, the sequencer pulses `start_i` for one clock. The timer then raises `busy_o` for exactly the programmed number of clocks, followed by a single-cycle `done_o`. The sequencer waits for `done_o` before it starts the next transfer.

The length of the wait is set by two inputs. With `prog_sel_i` high, the wait is 32 clocks for each step of the 8-bit `dly_count_i`, and a count of zero means 256 steps. With `prog_sel_i` low, a fixed standard wait of 17 clocks is used and the count is ignored.

Both inputs are captured on the clock edge that accepts the start pulse. Later changes to them have no effect on the wait already running.

The control is a three-state machine:
- IDLE is the rest state.
- RUN is the state in which the wait is counted.
- DONE is a one-cycle handshake state.

Its transitions are:
- LAUNCH (IDLE to RUN, on a start pulse).
- COUNT (RUN to RUN, while clocks remain).
- EXPIRE (RUN to DONE, when the last clock of the wait has elapsed).
- RELAUNCH (DONE to RUN, on a start pulse during the handshake cycle).
- RETIRE (DONE to IDLE, with no start pulse).

Top module: `deselect_delay_timer`

## Requirements
- R1: While reset is held and after it is released with no start pulse, `busy_o` and `done_o` are both low.
- R2: With `prog_sel_i` = 1 and `dly_count_i` = k, where 1 <= k <= 255, `busy_o` stays high for exactly 32*k consecutive clock cycles.
- R3: With `prog_sel_i` = 1 and `dly_count_i` = 0, `busy_o` stays high for exactly 8192 consecutive clock cycles.
- R4: With `prog_sel_i` = 0, `busy_o` stays high for exactly 17 clock cycles, whatever the value of `dly_count_i`.
- R5: A start pulse sampled high on a clock edge while the timer is not busy makes `busy_o` high from that edge onward.
- R6: `done_o` is high for exactly one cycle. That cycle immediately follows the last `busy_o` cycle, and `busy_o` is low during it.
- R7: `dly_count_i` and `prog_sel_i` are sampled on the edge that accepts the start pulse. Changing them during a wait does not change that wait's length.
- R8: A start pulse that arrives while `busy_o` is high is ignored: the wait in progress neither restarts nor lengthens.
- R9: A start pulse during the `done_o` cycle begins a new wait at once, so `busy_o` is high on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle end-of-transfer pulse from the sequencer |
| dly_count_i | input | 8 | Programmable delay count in 32-clock steps (0 means 256 steps) |
| prog_sel_i | input | 1 | 1 selects the programmable delay, 0 selects the 17-clock standard delay |
| busy_o | output | 1 | High while the deselect wait is being counted |
| done_o | output | 1 | One-cycle pulse when the wait has fully elapsed |

## Verification
`busy_o` is due one cycle after the edge that samples a start pulse. `done_o` is due exactly N+1 cycles after that edge, where N is the wait length in clocks.

The bench drives its inputs at the falling edge. A behavioural model advances on the rising edge and is compared with both outputs at every falling edge.

Separate directed runs count the falling edges on which `busy_o` is high. They then require `done_o` at the first falling edge after `busy_o` drops, for counts 1, 255, 0 and for the standard mode. Further runs repeat this measurement with the inputs disturbed and stray start pulses injected in the middle of a wait.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } dsd_state_e;

    localparam int unsigned DSD_STEP_CLKS_DEF = 32;
    localparam int unsigned DSD_STD_CLKS_DEF  = 17;
    localparam int unsigned DSD_CNT_W_DEF     = 8;

endpackage

// File: rtl/dsd_len_calc.sv
module dsd_len_calc #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned STEP_CLKS = 32,
    parameter int unsigned STD_CLKS  = 17,
    localparam int unsigned MAX_LEN  = (1 << CNT_W) * STEP_CLKS,
    localparam int unsigned LEN_W    = $clog2(MAX_LEN)
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic             prog_sel_i,
    output logic [LEN_W-1:0] len_m1_o
);

    logic [CNT_W:0] steps;
    logic [31:0]    prod;

    always_comb begin
        if (count_i == '0) begin
            steps = {1'b1, {CNT_W{1'b0}}};
        end else begin
            steps = {1'b0, count_i};
        end
        prod = 32'(steps) * 32'(STEP_CLKS);
        if (prog_sel_i) begin
            len_m1_o = LEN_W'(prod - 32'd1);
        end else begin
            len_m1_o = LEN_W'(STD_CLKS - 1);
        end
    end

endmodule

// File: rtl/dsd_down_counter.sv
module dsd_down_counter #(
    parameter int unsigned W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // While counting, the value only moves down by one: no reload mid-wait
    AST_NO_RELOAD_MIDWAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R8

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_i && !load_i) |=> $stable(cnt_q)); // R7

endmodule

// File: rtl/dsd_fsm.sv
module dsd_fsm
    import dsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_i,
    output logic load_o,
    output logic dec_o,
    output logic busy_o,
    output logic done_o
);

    dsd_state_e state_q, state_d;

    // next-state and state register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;          // LAUNCH
            ST_RUN:  if (zero_i)  state_d = ST_DONE;         // EXPIRE (else COUNT)
            ST_DONE: state_d = start_i ? ST_RUN : ST_IDLE;   // RELAUNCH / RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        dec_o  = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                dec_o  = 1'b1;
                busy_o = 1'b1;
            end
            ST_DONE: begin
                load_o = start_i;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o)); // R6

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !zero_i) |=> busy_o); // R8

endmodule

// File: rtl/deselect_delay_timer.sv
module deselect_delay_timer
    import dsd_pkg::*;
#(
    parameter int unsigned CNT_W     = DSD_CNT_W_DEF,
    parameter int unsigned STEP_CLKS = DSD_STEP_CLKS_DEF,
    parameter int unsigned STD_CLKS  = DSD_STD_CLKS_DEF,
    localparam int unsigned MAX_LEN  = (1 << CNT_W) * STEP_CLKS,
    localparam int unsigned LEN_W    = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] dly_count_i,
    input  logic             prog_sel_i,
    output logic             busy_o,
    output logic             done_o
);

    logic [LEN_W-1:0] len_m1;
    logic             load;
    logic             dec;
    logic             zero;

    dsd_len_calc #(
        .CNT_W     (CNT_W),
        .STEP_CLKS (STEP_CLKS),
        .STD_CLKS  (STD_CLKS)
    ) u_len (
        .count_i    (dly_count_i),
        .prog_sel_i (prog_sel_i),
        .len_m1_o   (len_m1)
    );

    dsd_down_counter #(
        .W (LEN_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (len_m1),
        .dec_i      (dec),
        .zero_o     (zero)
    );

    dsd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .zero_i  (zero),
        .load_o  (load),
        .dec_o   (dec),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    AST_NO_BOTH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R6

endmodule

// File: tb/deselect_delay_timer_tb_top.sv
module deselect_delay_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] dly_count_i = 8'd0;
    logic       prog_sel_i = 1'b0;
    logic       busy_o;
    logic       done_o;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    deselect_delay_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dly_count_i (dly_count_i),
        .prog_sel_i  (prog_sel_i),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    // behavioural reference model
    bit m_busy = 0;
    bit m_done = 0;
    int m_left = 0;

    function automatic int wait_len(input logic [7:0] c, input logic sel);
        if (!sel) return 17;
        return (c == 8'd0) ? 8192 : 32 * int'(c);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start_i) begin
                m_busy = 1;
                m_left = wait_len(dly_count_i, prog_sel_i);
            end
        end
    end

    // per-cycle comparison (R5, R6, R8, R9 through the model)
    always @(negedge clk) begin
        if (!finished) begin
            compared++;
            if (busy_o !== m_busy || done_o !== m_done) begin
                mismatched++;
                $display("FAIL R5/R6 model compare cyc=%0d: busy=%0b done=%0b expected busy=%0b done=%0b",
                         cyc, busy_o, done_o, m_busy, m_done);
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; starts a wait and measures it.
    task automatic run_delay(input logic [7:0] c, input logic sel, input int exp_n,
                             input string req, input bit disturb);
        int n = 0;
        dly_count_i = c;
        prog_sel_i  = sel;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R5 busy after start", int'(busy_o), 1);
        while (busy_o === 1'b1 && n < 9000) begin
            n++;
            if (disturb && n == 3) begin
                start_i     = 1'b1;
                dly_count_i = ~c;
                prog_sel_i  = ~sel;
            end
            if (disturb && n == 5) start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(n == exp_n, req, n, exp_n);
        check(done_o === 1'b1, "R6 done after busy", int'(done_o), 1);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0, "R1 busy in reset", int'(busy_o), 0);
        check(done_o === 1'b0, "R1 done in reset", int'(done_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 idle after reset",
              int'({busy_o, done_o}), 0);

        run_delay(8'd1,   1'b1, 32,   "R2 count 1", 0);
        @(negedge clk);
        check(done_o === 1'b0 && busy_o === 1'b0, "R6 done one cycle",
              int'({busy_o, done_o}), 0);
        run_delay(8'd255, 1'b1, 8160, "R2 count 255", 0);
        @(negedge clk);
        run_delay(8'd7,   1'b1, 224,  "R2 count 7", 0);
        @(negedge clk);
        run_delay(8'd0,   1'b1, 8192, "R3 count 0", 0);
        @(negedge clk);
        run_delay(8'd200, 1'b0, 17,   "R4 standard delay", 0);
        run_delay(8'd0,   1'b0, 17,   "R4 standard delay count 0 (R9 back-to-back)", 0);
        run_delay(8'd2,   1'b1, 64,   "R9 relaunch in done cycle", 0);
        repeat (2) @(negedge clk);
        run_delay(8'd3,   1'b1, 96,   "R7 R8 inputs changed and start during wait", 1);
        repeat (2) @(negedge clk);
        run_delay(8'd40,  1'b0, 17,   "R7 R8 standard mode with disturbance", 1);
        repeat (4) @(negedge clk);
        check(busy_o === 1'b0 && done_o === 1'b0, "R1 idle at end",
              int'({busy_o, done_o}), 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // watchdog
    always @(negedge clk) begin
        if (!finished && cyc > 150000) begin
            finished = 1;
            compared++;
            mismatched++;
            $display("FAIL R5 watchdog: cycles=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule